// File: doc/BRIEF.md
# Serial Flash Execute-in-Place Read Sequencer

This block sits on the host side of a serial NOR flash and turns single-word read requests into dual-line or quad-line fast-read transactions. A requester presents a 24-bit byte address on a valid/ready port. Some cycles later the block returns one 32-bit word with a single-cycle valid pulse. On the flash side it drives an active-low chip select and a mode-0 serial clock derived from the system clock. It also drives four I/O lines, each with its own output enable.

To cut per-read overhead, the block can leave the flash in opcode-less continuous mode. The mode byte sent after the address then carries the pattern that keeps the flash waiting for another address. The next read starts with the address straight away and skips the 8-clock opcode. The flash has no reset pin, so the block tracks this state itself. After its own reset, and whenever its configuration changes while idle, it sends an all-ones release burst before any read. The burst is as wide and as long as the transaction format the flash was last left in.

Top module: `xip_read_seq`

## Requirements
- R1: After reset, req_ready stays low and the first chip-select-low transaction is a release burst, issued before any read is accepted.
- R2: A release burst drives every enabled line high on every clock: 8 clocks with all four lines enabled when the width is quad, 16 clocks with only IO1..IO0 enabled when the width is dual.
- R3: A read that carries an opcode sends it first on IO0 only, MSB first, for 8 clocks: EBh for quad width, BBh for dual width. Chip select falls in the cycle after the request is accepted.
- R4: The 24-bit address and then the mode byte go out MSB first, 4 bits per clock on IO3..IO0 (quad) or 2 bits per clock on IO1..IO0 (dual). The mode byte is 20h (bits 5:4 = 10) when continuous mode is enabled and 00h otherwise.
- R5: When the previous read sent mode byte 20h and the configuration has not changed, the next read omits the opcode. A quad read then lasts 20 clocks instead of 28, and a dual read lasts 32 clocks instead of 40.
- R6: After the mode byte a quad read has 4 dummy clocks and a dual read has none. All output enables are low during the dummy and data clocks, and whenever chip select is high.
- R7: Data is read as 32 bits, each byte MSB first. The first byte received lands in bits 7:0 of rsp_data and the fourth in bits 31:24. rsp_valid is high for exactly one cycle per accepted request.
- R8: A change of the width or continuous-mode inputs while idle triggers a release burst using the width of the previous configuration. The following read carries the opcode.
- R9: The serial clock is low whenever chip select is high. I/O outputs and enables change only while the serial clock is low. Chip select stays high for at least one serial clock period between transactions.
- R10: req_ready is high only while chip select is high and no release is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_quad | input | 1 | 1 selects quad-line reads, 0 dual-line |
| cfg_cont | input | 1 | 1 keeps the flash in opcode-less continuous mode between reads |
| req_valid | input | 1 | Read request present |
| req_addr | input | 24 | Byte address of the word to read |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | One-cycle pulse with the returned word |
| rsp_data | output | 32 | Returned word, little-endian byte order |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_io_out | output | 4 | Values driven on IO3..IO0 |
| spi_io_oe | output | 4 | Per-line output enable for IO3..IO0 |
| spi_io_in | input | 4 | Values sampled from IO3..IO0 |

## Verification
The assertions assume the flash drives the I/O lines only in the data clocks of a read. They also assume that spi_io_in is stable from each rising serial clock edge until the following falling edge, which is what a mode-0 flash that updates on the falling edge provides. The bench's flash model drives its data after each falling edge and releases the lines when chip select rises. The bench changes cfg_quad and cfg_cont only while the block is between transactions and raises req_valid only while req_ready is observed high. This keeps every handshake and configuration switch inside the conditions the properties rely on.

// File: rtl/xip_pkg.sv
package xip_pkg;

    localparam int ADDR_W = 24;
    localparam int WORD_W = 32;

    localparam logic [7:0] OPC_QUAD_IO = 8'hEB;
    localparam logic [7:0] OPC_DUAL_IO = 8'hBB;
    localparam logic [7:0] MODE_KEEP   = 8'h20;
    localparam logic [7:0] MODE_LEAVE  = 8'h00;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RELEASE,
        PH_OPCODE,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_GAP
    } phase_e;

    typedef struct packed {
        logic quad;
        logic cont;
    } xcfg_t;

    typedef struct packed {
        logic [3:0] dout;
        logic [3:0] oe;
    } io_drv_t;

    // serial clocks spent in each phase
    function automatic logic [5:0] phase_clocks(input phase_e ph, input logic quad,
                                                input logic [5:0] dq, input logic [5:0] dd);
        case (ph)
            PH_RELEASE: return quad ? 6'd8 : 6'd16;
            PH_OPCODE:  return 6'd8;
            PH_ADDR:    return quad ? 6'd8 : 6'd16;
            PH_DUMMY:   return quad ? dq : dd;
            PH_DATA:    return quad ? 6'd8 : 6'd16;
            default:    return 6'd1;
        endcase
    endfunction

    // first received byte becomes the least significant one
    function automatic logic [31:0] le_word(input logic [31:0] s);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin
            r[8*i +: 8] = s[31-8*i -: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/xip_clkgen.sv
module xip_clkgen #(
    parameter int SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic sck_en,
    output logic sck,
    output logic bit_end,
    output logic sample
);
    localparam int PER = 2 * SCK_HALF;
    localparam int CW  = (PER > 2) ? $clog2(PER) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(PER - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bit_end = run && (cnt_q == CW'(PER - 1));
    assign sample  = run && (cnt_q == CW'(SCK_HALF));
    assign sck     = sck_en && (cnt_q >= CW'(SCK_HALF));

endmodule

// File: rtl/xip_rx.sv
module xip_rx
    import xip_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sample,
    input  logic        in_data,
    input  logic        last_data,
    input  logic        quad,
    input  logic [3:0]  io_in,
    output logic        rsp_valid,
    output logic [31:0] rsp_data
);
    logic [31:0] raw_q;
    logic [31:0] raw_nx;

    always_comb begin
        if (quad) raw_nx = {raw_q[27:0], io_in};
        else      raw_nx = {raw_q[29:0], io_in[1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (sample && in_data) begin
                raw_q <= raw_nx;
                if (last_data) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= le_word(raw_nx);
                end
            end
        end
    end

endmodule

// File: rtl/xip_ctrl.sv
module xip_ctrl
    import xip_pkg::*;
#(
    parameter int DUMMY_QUAD = 4,
    parameter int DUMMY_DUAL = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_quad,
    input  logic              cfg_cont,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              bit_end,
    output logic              run,
    output logic              sck_en,
    output logic              in_data,
    output logic              last_data,
    output logic              quad_act,
    output logic              cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe
);
    localparam logic [5:0] DQ = 6'(DUMMY_QUAD);
    localparam logic [5:0] DD = 6'(DUMMY_DUAL);

    phase_e     ph_q, ph_nx;
    logic [5:0] cnt_q;
    logic       wq_q;
    logic       need_rel_q;
    logic       cfg_ok_q;
    logic       in_cont_q;
    xcfg_t      lat_q;
    xcfg_t      cfg_now;
    logic [31:0] tx_q;
    logic [7:0] op_q;
    logic [5:0] ph_len;
    logic       last_clk;
    logic       cfg_diff;
    logic       start_rel;
    logic       accept;
    logic       has_dummy;
    io_drv_t    drv;

    assign cfg_now   = '{quad: cfg_quad, cont: cfg_cont};
    assign ph_len    = phase_clocks(ph_q, wq_q, DQ, DD);
    assign last_clk  = bit_end && (cnt_q == ph_len - 6'd1);
    assign cfg_diff  = cfg_ok_q && (cfg_now != lat_q);
    assign start_rel = (ph_q == PH_IDLE) && (need_rel_q || cfg_diff);
    assign req_ready = (ph_q == PH_IDLE) && !need_rel_q && cfg_ok_q && !cfg_diff;
    assign accept    = req_ready && req_valid;
    assign has_dummy = (wq_q ? DQ : DD) != 6'd0;

    always_comb begin
        case (ph_q)
            PH_RELEASE: ph_nx = PH_GAP;
            PH_OPCODE:  ph_nx = PH_ADDR;
            PH_ADDR:    ph_nx = has_dummy ? PH_DUMMY : PH_DATA;
            PH_DUMMY:   ph_nx = PH_DATA;
            PH_DATA:    ph_nx = PH_GAP;
            default:    ph_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q       <= PH_IDLE;
            cnt_q      <= '0;
            wq_q       <= 1'b1;
            need_rel_q <= 1'b1;
            cfg_ok_q   <= 1'b0;
            in_cont_q  <= 1'b0;
            lat_q      <= '0;
            tx_q       <= '0;
            op_q       <= '0;
        end else if (ph_q == PH_IDLE) begin
            cnt_q <= '0;
            if (start_rel) begin
                ph_q <= PH_RELEASE;
                wq_q <= cfg_ok_q ? lat_q.quad : cfg_quad;
            end else if (accept) begin
                wq_q <= lat_q.quad;
                tx_q <= {req_addr, lat_q.cont ? MODE_KEEP : MODE_LEAVE};
                op_q <= lat_q.quad ? OPC_QUAD_IO : OPC_DUAL_IO;
                ph_q <= in_cont_q ? PH_ADDR : PH_OPCODE;
            end
        end else if (bit_end) begin
            if (ph_q == PH_OPCODE) op_q <= {op_q[6:0], 1'b0};
            if (ph_q == PH_ADDR)   tx_q <= wq_q ? {tx_q[27:0], 4'h0} : {tx_q[29:0], 2'b00};
            if (last_clk) begin
                cnt_q <= '0;
                ph_q  <= ph_nx;
                if (ph_q == PH_RELEASE) begin
                    in_cont_q  <= 1'b0;
                    need_rel_q <= 1'b0;
                    cfg_ok_q   <= 1'b1;
                    lat_q      <= cfg_now;
                end
                if (ph_q == PH_DATA) begin
                    in_cont_q <= lat_q.cont;
                end
            end else begin
                cnt_q <= cnt_q + 6'd1;
            end
        end
    end

    always_comb begin
        drv = '{dout: 4'h0, oe: 4'h0};
        case (ph_q)
            PH_RELEASE: drv = '{dout: 4'hF, oe: wq_q ? 4'hF : 4'h3};
            PH_OPCODE:  drv = '{dout: {3'b000, op_q[7]}, oe: 4'h1};
            PH_ADDR:    drv = wq_q ? '{dout: tx_q[31:28], oe: 4'hF}
                               : '{dout: {2'b00, tx_q[31:30]}, oe: 4'h3};
            default:    drv = '{dout: 4'h0, oe: 4'h0};
        endcase
    end

    assign io_out    = drv.dout;
    assign io_oe     = drv.oe;
    assign cs_n      = (ph_q == PH_IDLE) || (ph_q == PH_GAP);
    assign run       = (ph_q != PH_IDLE);
    assign sck_en    = run && (ph_q != PH_GAP);
    assign in_data   = (ph_q == PH_DATA);
    assign last_data = in_data && (cnt_q == ph_len - 6'd1);
    assign quad_act  = wq_q;

endmodule

// File: rtl/xip_read_seq.sv
module xip_read_seq
    import xip_pkg::*;
#(
    parameter int SCK_HALF   = 2,
    parameter int DUMMY_QUAD = 4,
    parameter int DUMMY_DUAL = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_quad,
    input  logic        cfg_cont,
    input  logic        req_valid,
    input  logic [23:0] req_addr,
    output logic        req_ready,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic [3:0]  spi_io_out,
    output logic [3:0]  spi_io_oe,
    input  logic [3:0]  spi_io_in
);
    logic run, sck_en, bit_end, sample;
    logic in_data, last_data, quad_act;

    xip_clkgen #(.SCK_HALF(SCK_HALF)) clkgen_i (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .sck_en  (sck_en),
        .sck     (spi_sck),
        .bit_end (bit_end),
        .sample  (sample)
    );

    xip_ctrl #(.DUMMY_QUAD(DUMMY_QUAD), .DUMMY_DUAL(DUMMY_DUAL)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_quad  (cfg_quad),
        .cfg_cont  (cfg_cont),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .bit_end   (bit_end),
        .run       (run),
        .sck_en    (sck_en),
        .in_data   (in_data),
        .last_data (last_data),
        .quad_act  (quad_act),
        .cs_n      (spi_cs_n),
        .io_out    (spi_io_out),
        .io_oe     (spi_io_oe)
    );

    xip_rx rx_i (
        .clk       (clk),
        .rst       (rst),
        .sample    (sample),
        .in_data   (in_data),
        .last_data (last_data),
        .quad      (quad_act),
        .io_in     (spi_io_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

endmodule

// File: rtl/xip_read_seq_chk.sv
module xip_read_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       spi_cs_n,
    input logic       spi_sck,
    input logic [3:0] spi_io_out,
    input logic [3:0] spi_io_oe
);
    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst) spi_cs_n |-> !spi_sck); // R9
    AST_IO_HELD_SCK_HIGH: assert property (@(posedge clk) disable iff (rst) spi_sck |-> ($stable(spi_io_out) && $stable(spi_io_oe))); // R9
    AST_CS_GAP_HELD: assert property (@(posedge clk) disable iff (rst) $rose(spi_cs_n) |=> spi_cs_n); // R9
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid); // R7
    AST_READY_IDLE_ONLY: assert property (@(posedge clk) disable iff (rst) req_ready |-> spi_cs_n); // R10
    AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> !spi_cs_n); // R3
    AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk) disable iff (rst) spi_cs_n |-> (spi_io_oe == 4'h0)); // R6
endmodule

bind xip_read_seq xip_read_seq_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .spi_cs_n   (spi_cs_n),
    .spi_sck    (spi_sck),
    .spi_io_out (spi_io_out),
    .spi_io_oe  (spi_io_oe)
);

// File: tb/xip_read_seq_tb_top.sv
module xip_read_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_quad, cfg_cont;
    logic        req_valid;
    logic [23:0] req_addr;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_data;
    logic        spi_cs_n, spi_sck;
    logic [3:0]  spi_io_out, spi_io_oe, spi_io_in;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int n_req = 0, n_rsp = 0;
    logic [31:0] exp_q[$];

    always #10 clk = ~clk;

    xip_read_seq dut_i (
        .clk(clk), .rst(rst), .cfg_quad(cfg_quad), .cfg_cont(cfg_cont),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe),
        .spi_io_in(spi_io_in)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bv(input logic [23:0] a);
        return (a[7:0] * 8'd13) ^ a[15:8] ^ a[23:16];
    endfunction
    function automatic logic [31:0] word_at(input logic [23:0] a);
        return {bv(a + 24'd3), bv(a + 24'd2), bv(a + 24'd1), bv(a)};
    endfunction
    function automatic logic [31:0] stream_at(input logic [23:0] a);
        return {bv(a), bv(a + 24'd1), bv(a + 24'd2), bv(a + 24'd3)};
    endfunction

    // behavioural flash: starts out stuck in quad continuous mode
    int          f_st = 0, f_w = 4, fk = 0, f_dk = 0;
    logic        f_cont = 1'b1;
    logic [7:0]  f_op;
    logic [31:0] f_am, f_stream, f_tmp;
    logic [3:0]  f_oe = 4'h0, f_val = 4'h0;
    logic [23:0] f_last_addr = '0;
    logic [7:0]  f_last_mode = '0;

    assign spi_io_in = (f_val & f_oe) | ~f_oe;

    always @(negedge spi_cs_n) begin
        fk = 0; f_op = '0; f_am = '0; f_dk = 0; f_oe = 4'h0;
        f_st = f_cont ? 2 : 1;
    end
    always @(posedge spi_sck) if (!spi_cs_n) begin
        case (f_st)
            1: begin
                f_op = {f_op[6:0], spi_io_out[0]}; fk++;
                if (fk == 8) begin
                    fk = 0;
                    if (f_op == 8'hEB) begin f_w = 4; f_st = 2; end
                    else if (f_op == 8'hBB) begin f_w = 2; f_st = 2; end
                    else f_st = 5;
                end
            end
            2: begin
                f_am = (f_w == 4) ? {f_am[27:0], spi_io_out} : {f_am[29:0], spi_io_out[1:0]};
                fk++;
                if (fk == 32 / f_w) begin
                    fk = 0;
                    f_stream = stream_at(f_am[31:8]);
                    f_st = (f_w == 4) ? 3 : 4;
                end
            end
            3: begin fk++; if (fk == 4) begin fk = 0; f_st = 4; end end
            4: f_dk++;
            default: ;
        endcase
    end
    always @(negedge spi_sck) if (!spi_cs_n && f_st == 4 && f_dk < 32 / f_w) begin
        f_tmp = f_stream << (f_dk * f_w);
        f_oe  = (f_w == 4) ? 4'hF : 4'h3;
        f_val = (f_w == 4) ? f_tmp[31:28] : {2'b00, f_tmp[31:30]};
    end
    always @(posedge spi_cs_n) begin
        if (f_st == 3 || f_st == 4) begin
            f_cont = (f_am[5:4] == 2'b10);
            f_last_addr = f_am[31:8];
            f_last_mode = f_am[7:0];
        end
        f_st = 0; f_oe = 4'h0;
    end

    // transaction monitor
    int         t_len;
    logic [7:0] t_op;
    logic       t_ones;
    logic [3:0] t_oe0;
    int q_len[$];
    logic [7:0] q_op[$];
    logic q_ones[$];
    logic [3:0] q_oe0[$];
    int rise_cyc = -1, min_gap = 1000;

    always @(negedge spi_cs_n) begin
        t_len = 0; t_op = '0; t_ones = 1'b1; t_oe0 = '0;
        if (rise_cyc >= 0 && cyc - rise_cyc < min_gap) min_gap = cyc - rise_cyc;
    end
    always @(posedge spi_sck) if (!spi_cs_n) begin
        if (t_len < 8) t_op = {t_op[6:0], spi_io_out[0]};
        if (t_len == 0) t_oe0 = spi_io_oe;
        if (spi_io_oe == 4'h0 || (spi_io_out & spi_io_oe) != spi_io_oe) t_ones = 1'b0;
        t_len++;
    end
    always @(posedge spi_cs_n) if (!rst) begin
        q_len.push_back(t_len); q_op.push_back(t_op);
        q_ones.push_back(t_ones); q_oe0.push_back(t_oe0);
        rise_cyc = cyc;
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk(!(spi_cs_n && spi_sck), "R9 sck low while deselected", {31'b0, spi_sck}, 32'h0);
            if (!spi_cs_n) begin
                chk((f_oe & spi_io_oe) == 4'h0, "R6 line contention", {28'b0, spi_io_oe}, 32'h0);
                chk(!req_ready, "R10 ready while busy", {31'b0, req_ready}, 32'h0);
            end
            if (rsp_valid) begin
                n_rsp++;
                if (exp_q.size() == 0) chk(1'b0, "R7 unexpected response", rsp_data, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_data == e, "R7 read data", rsp_data, e);
                end
            end
        end
    end

    task automatic pop_txn(output int len, output logic [7:0] op, output logic ones, output logic [3:0] oe0);
        while (q_len.size() == 0) @(negedge clk);
        len = q_len.pop_front(); op = q_op.pop_front();
        ones = q_ones.pop_front(); oe0 = q_oe0.pop_front();
    endtask

    task automatic expect_release(input int exp_len, input logic [3:0] exp_oe, input string req);
        int len; logic [7:0] op; logic ones; logic [3:0] oe0;
        pop_txn(len, op, ones, oe0);
        chk(len == exp_len, {req, " release length"}, len, exp_len);
        chk(ones, {req, " release all ones"}, {31'b0, ones}, 32'h1);
        chk(oe0 == exp_oe, {req, " release enables"}, {28'b0, oe0}, {28'b0, exp_oe});
    endtask

    task automatic do_read(input logic [23:0] a, input int exp_len, input bit has_op,
                           input logic [7:0] exp_op, input logic [7:0] exp_mode, input string req);
        int len; logic [7:0] op; logic ones; logic [3:0] oe0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        exp_q.push_back(word_at(a)); n_req++;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!spi_cs_n, "R3 select after accept", {31'b0, spi_cs_n}, 32'h0);
        while (n_rsp < n_req) @(negedge clk);
        pop_txn(len, op, ones, oe0);
        chk(len == exp_len, {req, " clock count"}, len, exp_len);
        if (has_op) chk(op == exp_op, "R3 opcode", {24'b0, op}, {24'b0, exp_op});
        chk(f_last_addr == a, "R4 address seen by flash", {8'b0, f_last_addr}, {8'b0, a});
        chk(f_last_mode == exp_mode, "R4 mode byte", {24'b0, f_last_mode}, {24'b0, exp_mode});
    endtask

    initial begin
        rst = 1'b1; cfg_quad = 1'b1; cfg_cont = 1'b1; req_valid = 1'b0; req_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1 reset cs", {31'b0, spi_cs_n}, 32'h1);
        chk(spi_sck == 1'b0, "R1 reset sck", {31'b0, spi_sck}, 32'h0);
        chk(req_ready == 1'b0, "R1 reset ready", {31'b0, req_ready}, 32'h0);
        chk(rsp_valid == 1'b0, "R1 reset valid", {31'b0, rsp_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R1 no ready before release", {31'b0, req_ready}, 32'h0);
        expect_release(8, 4'hF, "R1 R2 quad");
        // quad, continuous
        do_read(24'h001000, 28, 1, 8'hEB, 8'h20, "R3 R6 quad first");
        do_read(24'h0ABCDE, 20, 0, 8'h00, 8'h20, "R5 quad continuous");
        do_read(24'hFFFFFD, 20, 0, 8'h00, 8'h20, "R5 R7 wrap");
        // continuous off
        cfg_cont = 1'b0;
        expect_release(8, 4'hF, "R8 cont off");
        do_read(24'h123456, 28, 1, 8'hEB, 8'h00, "R8 opcode after change");
        do_read(24'h00ABC0, 28, 1, 8'hEB, 8'h00, "R5 opcode kept");
        // dual, continuous
        cfg_quad = 1'b0; cfg_cont = 1'b1;
        expect_release(8, 4'hF, "R8 old width");
        do_read(24'h345678, 40, 1, 8'hBB, 8'h20, "R3 R6 dual first");
        do_read(24'h765432, 32, 0, 8'h00, 8'h20, "R5 dual continuous");
        // back to quad: release in dual width
        cfg_quad = 1'b1;
        expect_release(16, 4'h3, "R2 R8 dual");
        do_read(24'h00FF00, 28, 1, 8'hEB, 8'h20, "R8 quad again");
        repeat (10) @(negedge clk);
        chk(n_rsp == n_req, "R7 one response per request", n_rsp, n_req);
        chk(min_gap >= 4, "R9 deselect gap", min_gap, 4);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule